// File: doc/BRIEF.md
# Event Counter Monitor

The block is a compact performance monitor with four 32-bit counters. Each counter takes an 8-bit event code from a shared event-select register and, depending on that code, counts every core clock or every cycle in which the retire pulse is high. A control register carries a global freeze flag and two per-counter freeze flags. While a counter is frozen, or while its code is not one it recognises, its value holds. The first counter accepts two extra codes, one for cycles and one for instructions, that the other three counters ignore.

Software reaches the control register, the event-select register and the four counters through a single-cycle register port. A write takes effect at the next clock edge. Reads are combinational and return the value as it stands before that cycle's increment. The unit comes out of reset globally frozen, so nothing counts until software clears the freeze flag.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset the control register reads 0x80000000, the event-select register and all counters read 0, and no counter advances while bit 31 (global freeze) stays set.
- R2: Event code 0x02 makes any counter an instruction counter.
- R3: Event code 0x1E makes any counter a cycle counter.
- R4: On counter 1 only, code 0xF0 selects cycles and code 0xFE selects instructions. On counters 2 to 4 these two codes are inactive.
- R5: With control bit 31 set, every counter holds its value whatever its event code.
- R6: Control bit 1 freezes counter 1 alone, and control bit 2 freezes counters 2, 3 and 4 together. Neither affects the other counters.
- R7: A cycle counter that is not frozen adds exactly one on every clock edge.
- R8: Register map: address 0 is the control register, address 1 is event select, and addresses 2 to 5 are counters 1 to 4. Event-select bits [31:24], [23:16], [15:8] and [7:0] hold the codes of counters 1, 2, 3 and 4. Every control bit other than 31, 2 and 1 is stored, reads back as written and has no effect on counting.
- R9: An instruction counter that is not frozen adds one only on clock edges where the retire input is high.
- R10: A register write to a counter loads the written value and overrides that cycle's increment. A read in the same cycle returns the value from before the increment.
- R11: Counters wrap from 0xFFFFFFFF to 0.
- R12: Any event code other than those in R2 to R4 is inactive and the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address (map in R8) |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data of the addressed register; 0 for unmapped addresses |
| retireIn | input | 1 | High for one cycle per retired instruction |

## Verification
The hardest case to reach from the ports is a counter write landing in the same cycle that the counter would have advanced, because the counter must be live at that moment. The bench first leaves counter 1 running in cycle mode, then writes it and reads it back in the cycles just after the write to check for the missing increment. Each vector also makes the frozen or unfrozen transitions happen through register writes whose own cycles must count or not count. The expected totals therefore include the unfreeze and freeze write cycles, counted exactly.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int PMU_CTRS = 4;
  localparam int PMU_DW   = 32;
  localparam int PMU_EW   = 8;
  localparam int PMU_AW   = 3;

  // register map
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_EVT  = 1;
  localparam int ADDR_CTR0 = 2;

  // control bits that act on counting
  localparam int BIT_GFREEZE   = 31;
  localparam int BIT_FRZ_FIRST = 1;
  localparam int BIT_FRZ_REST  = 2;
  localparam logic [PMU_DW-1:0] CTRL_RESET = PMU_DW'(1) << BIT_GFREEZE;

  localparam logic [PMU_EW-1:0] CODE_INSTR     = 8'h02;
  localparam logic [PMU_EW-1:0] CODE_CYC       = 8'h1E;
  localparam logic [PMU_EW-1:0] CODE_CYC_ARCH  = 8'hF0;
  localparam logic [PMU_EW-1:0] CODE_INST_ARCH = 8'hFE;

  typedef enum logic [1:0] {EV_IDLE, EV_CYCLE, EV_RETIRE} evKind_t;

  typedef struct packed {
    logic [PMU_CTRS-1:0] ctrLoad;
    logic [PMU_CTRS-1:0] ctrStep;
    logic [PMU_DW-1:0]   loadData;
  } ctrStrobe_t;

  function automatic evKind_t decodeEvent(input logic [PMU_EW-1:0] code,
                                          input logic isFirst);
    evKind_t k;
    case (code)
      CODE_INSTR:     k = EV_RETIRE;
      CODE_CYC:       k = EV_CYCLE;
      CODE_CYC_ARCH:  k = isFirst ? EV_CYCLE : EV_IDLE;
      CODE_INST_ARCH: k = isFirst ? EV_RETIRE : EV_IDLE;
      default:        k = EV_IDLE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/pmu_control.sv
module pmu_control
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = PMU_CTRS,
  parameter int DW      = PMU_DW,
  parameter int EW      = PMU_EW,
  parameter int AW      = PMU_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  input  logic          retireIn,
  output logic [DW-1:0] ctrlQ,
  output logic [DW-1:0] evtQ,
  output ctrStrobe_t    strobes
);
  localparam logic [AW-1:0] CTRL_A = AW'(ADDR_CTRL);
  localparam logic [AW-1:0] EVT_A  = AW'(ADDR_EVT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlQ <= CTRL_RESET;
      evtQ  <= '0;
    end else if (regWrEn) begin
      if (regAddr == CTRL_A) ctrlQ <= regWrData;
      if (regAddr == EVT_A)  evtQ  <= regWrData;
    end
  end

  assign strobes.loadData = regWrData;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctl
    localparam logic [AW-1:0] MY_A = AW'(ADDR_CTR0 + i);
    localparam int FRZ_BIT = (i == 0) ? BIT_FRZ_FIRST : BIT_FRZ_REST;
    logic [EW-1:0] code;
    logic          frozen;
    evKind_t       kind;

    assign code   = evtQ[(NUM_CTR-1-i)*EW +: EW];
    assign frozen = ctrlQ[BIT_GFREEZE] | ctrlQ[FRZ_BIT];
    assign kind   = frozen ? EV_IDLE : decodeEvent(code, i == 0);
    assign strobes.ctrStep[i] = (kind == EV_CYCLE) | ((kind == EV_RETIRE) & retireIn);
    assign strobes.ctrLoad[i] = regWrEn & (regAddr == MY_A);
  end
endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = PMU_CTRS,
  parameter int DW      = PMU_DW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrStrobe_t                  strobes,
  output logic [NUM_CTR-1:0][DW-1:0]  ctrVals
);
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n)                  ctrVals[i] <= '0;
      else if (strobes.ctrLoad[i]) ctrVals[i] <= strobes.loadData;
      else if (strobes.ctrStep[i]) ctrVals[i] <= ctrVals[i] + DW'(1);
    end
  end
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = PMU_CTRS,
  parameter int DW      = PMU_DW,
  parameter int EW      = PMU_EW,
  parameter int AW      = PMU_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic          retireIn
);
  logic [DW-1:0]              ctrlQ;
  logic [DW-1:0]              evtQ;
  logic [NUM_CTR-1:0][DW-1:0] ctrVals;
  ctrStrobe_t                 strobes;

  pmu_control #(.NUM_CTR(NUM_CTR), .DW(DW), .EW(EW), .AW(AW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .retireIn(retireIn),
    .ctrlQ(ctrlQ), .evtQ(evtQ), .strobes(strobes)
  );

  pmu_datapath #(.NUM_CTR(NUM_CTR), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .ctrVals(ctrVals)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == AW'(ADDR_CTRL)) regRdData = ctrlQ;
    if (regAddr == AW'(ADDR_EVT))  regRdData = evtQ;
    for (int i = 0; i < NUM_CTR; i++)
      if (regAddr == AW'(ADDR_CTR0 + i)) regRdData = ctrVals[i];
  end
endmodule

// File: rtl/pmu_counter_unit_chk.sv
module pmu_counter_unit_chk
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = PMU_CTRS,
  parameter int DW      = PMU_DW,
  parameter int EW      = PMU_EW,
  parameter int AW      = PMU_AW
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [AW-1:0]              regAddr,
  input logic                       regWrEn,
  input logic [DW-1:0]              regWrData,
  input logic                       retireIn,
  input logic [DW-1:0]              ctrlView,
  input logic [DW-1:0]              evtView,
  input logic [NUM_CTR-1:0][DW-1:0] ctrView
);
  logic anyCtrWr;
  assign anyCtrWr = regWrEn && (regAddr >= AW'(ADDR_CTR0))
                            && (regAddr < AW'(ADDR_CTR0 + NUM_CTR));

  logic ctr1Wr;
  assign ctr1Wr = regWrEn && (regAddr == AW'(ADDR_CTR0));
  logic ctr2Wr;
  assign ctr2Wr = regWrEn && (regAddr == AW'(ADDR_CTR0 + 1));

  // R1: first cycle out of reset shows the frozen reset state
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (ctrlView == CTRL_RESET && evtView == '0 && ctrView == '0));

  // R5: global freeze holds every counter
  a_r5_global_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlView[BIT_GFREEZE] && !anyCtrWr) |=> $stable(ctrView));

  // R6: bit 1 freezes counter 1
  a_r6_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlView[BIT_FRZ_FIRST] && !ctr1Wr) |=> $stable(ctrView[0]));

  // R7: live cycle counter on counter 1 steps by one
  a_r7_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlView[BIT_GFREEZE] && !ctrlView[BIT_FRZ_FIRST]
      && evtView[DW-1 -: EW] == CODE_CYC && !ctr1Wr)
    |=> ctrView[0] == $past(ctrView[0]) + DW'(1));

  // R9: instruction counter 2 holds when retire is low
  a_r9_no_retire_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evtView[DW-1-EW -: EW] == CODE_INSTR && !retireIn && !ctr2Wr)
    |=> $stable(ctrView[1]));

  // R10: a counter write wins over the increment
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_wr
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (regWrEn && regAddr == AW'(ADDR_CTR0 + i)) |=> ctrView[i] == $past(regWrData));
  end
endmodule

bind pmu_counter_unit pmu_counter_unit_chk #(
  .NUM_CTR(NUM_CTR), .DW(DW), .EW(EW), .AW(AW)
) chk (
  .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .retireIn(retireIn),
  .ctrlView(ctrlQ), .evtView(evtQ), .ctrView(ctrVals)
);

// File: tb/pmu_counter_unit_test.sv
module pmu_counter_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        retireIn = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  pmu_counter_unit uut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .retireIn(retireIn)
  );

  localparam int IDLE_N   = 10;
  localparam int RETIRE_N = 4;
  localparam logic [31:0] FRZ = 32'h8000_0000;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] evt;
    logic [31:0] e1, e2, e3, e4;
  } vec_t;

  // cycles counted = IDLE_N + 1 (freeze write cycle) = 11, instructions = 4
  localparam vec_t VEC [7] = '{
    '{32'h0,        32'h1E021E02, 32'd11, 32'd4,  32'd11, 32'd4 },  // R2 R3 R7 R9
    '{32'h0,        32'hF0F0021E, 32'd11, 32'd0,  32'd4,  32'd11},  // R4
    '{32'h0,        32'hFEFE5500, 32'd4,  32'd0,  32'd0,  32'd0 },  // R4 R12
    '{32'h2,        32'h1E1E1E02, 32'd0,  32'd11, 32'd11, 32'd4 },  // R6
    '{32'h4,        32'h1E1E021E, 32'd11, 32'd0,  32'd0,  32'd0 },  // R6
    '{32'h8000_0000,32'h1E1E1E1E, 32'd0,  32'd0,  32'd0,  32'd0 },  // R5
    '{32'h7FFF_FFF9,32'h1E021E02, 32'd11, 32'd4,  32'd11, 32'd4 }   // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    retireIn = 1'b0; regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic idle(input int n, input int r);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      retireIn = (k < r);
    end
  endtask

  initial begin
    #(100000 * 10);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    regRead(3'd0, v); check("R1 ctrl reset", v, FRZ);
    regRead(3'd1, v); check("R1 evt reset", v, 32'h0);
    regRead(3'd2, v); check("R1 ctr1 reset", v, 32'h0);
    regRead(3'd5, v); check("R1 ctr4 reset", v, 32'h0);
    regWrite(3'd1, 32'h1E1E1E1E);
    idle(5, 5);
    regRead(3'd2, v); check("R1 no count while reset-frozen", v, 32'h0);
    regRead(3'd4, v); check("R1 no count ctr3", v, 32'h0);

    // vector table
    foreach (VEC[n]) begin
      regWrite(3'd0, FRZ);
      for (int c = 0; c < 4; c++) regWrite(3'(2 + c), 32'h0);
      regWrite(3'd1, VEC[n].evt);
      regWrite(3'd0, VEC[n].ctrl);
      regRead(3'd0, v); check("R8 ctrl readback", v, VEC[n].ctrl);
      idle(IDLE_N - 1, RETIRE_N);
      regWrite(3'd0, FRZ);
      regRead(3'd1, v); check("R8 evt readback", v, VEC[n].evt);
      regRead(3'd2, v); check($sformatf("vec%0d ctr1 R2 R3 R4 R5 R6 R7 R8 R9 R12", n), v, VEC[n].e1);
      regRead(3'd3, v); check($sformatf("vec%0d ctr2 R2 R3 R4 R5 R6 R7 R8 R9 R12", n), v, VEC[n].e2);
      regRead(3'd4, v); check($sformatf("vec%0d ctr3 R2 R3 R4 R5 R6 R7 R8 R9 R12", n), v, VEC[n].e3);
      regRead(3'd5, v); check($sformatf("vec%0d ctr4 R2 R3 R4 R5 R6 R7 R8 R9 R12", n), v, VEC[n].e4);
    end

    // R11: wrap
    regWrite(3'd0, FRZ);
    regWrite(3'd2, 32'hFFFF_FFFE);
    regWrite(3'd1, 32'h1E000000);
    regWrite(3'd0, 32'h0);
    idle(1, 0);
    regWrite(3'd0, FRZ);
    regRead(3'd2, v); check("R11 wrap to zero", v, 32'h0);

    // R10: write beats increment while counter 1 runs
    regWrite(3'd0, 32'h0);
    idle(3, 0);
    regWrite(3'd2, 32'd100);
    check("R10 write overrides step", regRdData, 32'd100);
    @(posedge clk); #1;
    check("R10 pre-increment read then step", regRdData, 32'd101);
    regWrite(3'd0, FRZ);

    // unmapped address reads zero
    regRead(3'd7, v); check("R8 unmapped read", v, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule